// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a 4096-byte serial EEPROM. The memory is an internal register array. A system clock samples the SCL and SDA lines. The block detects Start and Stop conditions on the bus and responds to a device address word whose upper nibble is the EEPROM type code and whose next three bits match three strap inputs.

A write transaction sends two address bytes that form a 12-bit word address, then one or more data bytes. The data bytes collect in a 32-byte page buffer. The buffer goes to the array when the next Stop arrives, and that Stop also begins a self-timed write cycle. While the cycle runs, the bus is ignored. A read transaction returns bytes from the internal address counter. A random read is a write of the address followed by a repeated Start and a read.

The block only ever pulls SDA low, through a low-enable output. The surrounding logic turns that output into the open-drain pad.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, `sdaDriveLow` is 0 and `busy` is 0.
- R2: A device address word is acknowledged (SDA low in the ninth clock) only when bits 7..4 are 1010 and bits 3..1 equal `strap[2:0]`. Any other word gets no acknowledge, and the block ignores the bus until the next Start.
- R3: After a write address word (bit 0 = 0), two address bytes are each acknowledged. The word address is {first byte bits 3..0, second byte}.
- R4: A data byte that follows the address bytes is acknowledged. After the write cycle it reads back at its address.
- R5: In a multi-byte write, the low 5 address bits increment after each data byte and wrap from 31 to 0. The upper 7 page bits never change, and partial pages leave the unwritten bytes alone.
- R6: A Stop that ends a write holding at least one accepted data byte raises `busy` exactly 3 clocks after SDA rises on the pins. `busy` stays high for exactly WRITE_CYCLES clocks. A Stop with no accepted data byte leaves `busy` low.
- R7: While `busy` is high, the block never pulls SDA low and ignores all bus activity, including Start and Stop.
- R8: While `wrProtect` is high, data bytes get no acknowledge and the memory array is unchanged.
- R9: A read address word (bit 0 = 1) returns bytes MSB first from the address counter. The counter advances after each byte the controller acknowledges. A missing acknowledge ends the read.
- R10: `sdaDriveLow` changes only while SCL is low, never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired-AND result) |
| strap | input | 3 | Device address select bits |
| wrProtect | input | 1 | High blocks all data writes |
| sdaDriveLow | output | 1 | High pulls SDA low |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
Each bus pin passes through a two-flop synchronizer and is then compared with its previous value. Every bus event therefore takes effect in the third clock after the pin changes. The acknowledge and read data appear on `sdaDriveLow` three clocks after a SCL fall, and `busy` rises three clocks after the Stop edge on SDA. The bench holds each SCL phase for ten clocks and samples SDA in the middle of SCL high, so no sample falls near an update. The busy timing is checked exactly: `busy` must be 0 two clocks after the Stop edge and 1 one clock later, and its high run is counted clock by clock against WRITE_CYCLES.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK
  } ctlState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic storeData;
    logic advRead;
    logic commit;
    logic clearPage;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_eeprom_dp.sv
module i2c_eeprom_dp
  import i2c_eeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 4096,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] rxByte,
  output logic [7:0] readByte,
  output logic       busy
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [ADDR_W-1:0]  addrCnt;
  logic [7:0]         memArr  [MEM_BYTES];
  logic [7:0]         pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [CNT_W-1:0]   busyCnt;
  logic [PAGE_W-1:0]  pageSel;
  logic [OFF_W-1:0]   offset;

  assign pageSel  = addrCnt[ADDR_W-1:OFF_W];
  assign offset   = addrCnt[OFF_W-1:0];
  assign readByte = memArr[addrCnt];
  assign busy     = (busyCnt != '0);

  // address counter: full wrap on reads, in-page wrap on writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (strobe.loadHi) begin
      addrCnt[ADDR_W-1:8] <= rxByte[HI_W-1:0];
    end else if (strobe.loadLo) begin
      addrCnt[7:0] <= rxByte;
    end else if (strobe.storeData) begin
      addrCnt[OFF_W-1:0] <= offset + 1'b1;
    end else if (strobe.advRead) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  // page buffer valid mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageMask <= '0;
    end else if (strobe.commit || strobe.clearPage) begin
      pageMask <= '0;
    end else if (strobe.storeData) begin
      pageMask[offset] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeData) pageBuf[offset] <= rxByte;
  end

  // array update at the start of the write cycle
  always_ff @(posedge clk) begin
    if (strobe.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageMask[i]) memArr[{pageSel, OFF_W'(i)}] <= pageBuf[i];
      end
    end
  end

  // write cycle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strobe.commit && (pageMask != '0)) begin
      busyCnt <= CNT_W'(WRITE_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/i2c_eeprom_ctl.sv
module i2c_eeprom_ctl
  import i2c_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclQ,
  input  logic       sdaQ,
  input  logic [2:0] strap,
  input  logic       wrProtect,
  input  logic       busy,
  input  logic [7:0] readByte,
  output dpStrobe_t  strobe,
  output logic [7:0] rxByte,
  output logic       sdaDriveLow
);

  ctlState_t  state, afterAck;
  logic       sclPrev, sdaPrev;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic       ackDrive, txEn, hostAck;
  logic       sclRise, sclFall, startEv, stopEv, active, byteDone, devMatch;

  assign sclRise  = sclQ & ~sclPrev;
  assign sclFall  = ~sclQ & sclPrev;
  assign startEv  = sclQ & sclPrev & sdaPrev & ~sdaQ;
  assign stopEv   = sclQ & sclPrev & ~sdaPrev & sdaQ;
  assign active   = ~busy & ~startEv & ~stopEv;
  assign byteDone = active & sclFall & (bitCnt == 4'd8);
  assign devMatch = (rxShift[7:4] == DEV_TYPE_CODE) && (rxShift[3:1] == strap);
  assign rxByte   = rxShift;

  assign sdaDriveLow = ackDrive | (txEn & ~txShift[7]);

  always_comb begin
    strobe           = '0;
    strobe.loadHi    = byteDone && (state == ST_AHI);
    strobe.loadLo    = byteDone && (state == ST_ALO);
    strobe.storeData = byteDone && (state == ST_WDAT) && !wrProtect;
    strobe.advRead   = active && (state == ST_RACK) && sclRise && !sdaQ;
    strobe.commit    = stopEv && !busy;
    strobe.clearPage = startEv && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
      hostAck  <= 1'b0;
    end else if (busy) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else if (startEv) begin
      state    <= ST_DEV;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else if (stopEv) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (sclRise && bitCnt != 4'd8) begin
            rxShift <= {rxShift[6:0], sdaQ};
            bitCnt  <= bitCnt + 1'b1;
          end else if (byteDone) begin
            bitCnt <= '0;
            state  <= ST_ACK;
            ackDrive <= 1'b1;
            unique case (state)
              ST_DEV: begin
                if (!devMatch) begin
                  state    <= ST_IDLE;
                  ackDrive <= 1'b0;
                end
                afterAck <= rxShift[0] ? ST_RDAT : ST_AHI;
              end
              ST_AHI: afterAck <= ST_ALO;
              ST_ALO: afterAck <= ST_WDAT;
              default: begin
                afterAck <= ST_WDAT;
                if (wrProtect) begin
                  state    <= ST_IDLE;
                  ackDrive <= 1'b0;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            state    <= afterAck;
            bitCnt   <= '0;
            if (afterAck == ST_RDAT) begin
              txShift <= readByte;
              txEn    <= 1'b1;
            end
          end
        end
        ST_RDAT: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              txEn   <= 1'b0;
              state  <= ST_RACK;
              bitCnt <= '0;
            end else begin
              txShift <= {txShift[6:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            hostAck <= ~sdaQ;
          end else if (sclFall) begin
            if (hostAck) begin
              state   <= ST_RDAT;
              txShift <= readByte;
              txEn    <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 4096,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       wrProtect,
  output logic       sdaDriveLow,
  output logic       busy
);

  logic      sclMeta, sdaMeta, sclQ, sdaQ;
  dpStrobe_t strobe;
  logic [7:0] rxByte, readByte;

  // two-flop synchronizers for the bus pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1;
      sdaMeta <= 1'b1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclMeta <= sclIn;
      sdaMeta <= sdaIn;
      sclQ    <= sclMeta;
      sdaQ    <= sdaMeta;
    end
  end

  i2c_eeprom_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .sclQ       (sclQ),
    .sdaQ       (sdaQ),
    .strap      (strap),
    .wrProtect  (wrProtect),
    .busy       (busy),
    .readByte   (readByte),
    .strobe     (strobe),
    .rxByte     (rxByte),
    .sdaDriveLow(sdaDriveLow)
  );

  i2c_eeprom_dp #(
    .MEM_BYTES   (MEM_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxByte  (rxByte),
    .readByte(readByte),
    .busy    (busy)
  );

endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk #(
  parameter int WRITE_CYCLES = 200
) (
  input logic clk,
  input logic rstN,
  input logic sclQ,
  input logic sdaQ,
  input logic sdaDriveLow,
  input logic busy
);

  localparam int RUN_W = $clog2(WRITE_CYCLES + 2);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaDriveLow);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RUN_W'(WRITE_CYCLES)));

  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(WRITE_CYCLES));

  // R6
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(sdaQ) && $past(sclQ)));

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclQ && $past(sclQ)) |-> $stable(sdaDriveLow));

endmodule

bind i2c_eeprom_target i2c_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .sclQ       (sclQ),
  .sdaQ       (sdaQ),
  .sdaDriveLow(sdaDriveLow),
  .busy       (busy)
);

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;

  localparam int WCYC = 200;
  localparam int Q    = 10;
  localparam logic [7:0] DEV_WR = 8'hAA; // 1010 101 0
  localparam logic [7:0] DEV_RD = 8'hAB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wrProtect = 1'b0;
  logic sdaDriveLow, busy;
  logic sdaLine;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaDriveLow;

  i2c_eeprom_target #(.WRITE_CYCLES(WCYC)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclDrv),
    .sdaIn      (sdaLine),
    .strap      (strap),
    .wrProtect  (wrProtect),
    .sdaDriveLow(sdaDriveLow),
    .busy       (busy)
  );

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitq(Q);
    sclDrv = 1'b1; waitq(Q);
    sdaDrv = 1'b0; waitq(Q);
    sclDrv = 1'b0; waitq(Q);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitq(Q);
    sclDrv = 1'b1; waitq(Q);
    sdaDrv = 1'b1; waitq(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitq(Q);
      sclDrv = 1'b1; waitq(Q);
      sclDrv = 1'b0; waitq(Q);
    end
    sdaDrv = 1'b1; waitq(Q);
    sclDrv = 1'b1; waitq(Q / 2);
    ack = ~sdaLine; waitq(Q / 2);
    sclDrv = 1'b0; waitq(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclDrv = 1'b1; waitq(Q / 2);
      b[i] = sdaLine; waitq(Q / 2);
      sclDrv = 1'b0; waitq(Q);
    end
    sdaDrv = ~ackIt; waitq(Q);
    sclDrv = 1'b1; waitq(Q);
    sclDrv = 1'b0; waitq(Q);
    sdaDrv = 1'b1;
  endtask

  task automatic setAddr(input logic [11:0] a, input string tag);
    logic ack;
    startCond();
    sendByte(DEV_WR, ack); checkVal({tag, " R2 dev ack"}, ack, 1'b1);
    sendByte({4'h0, a[11:8]}, ack); checkVal({tag, " R3 hi ack"}, ack, 1'b1);
    sendByte(a[7:0], ack); checkVal({tag, " R3 lo ack"}, ack, 1'b1);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < WCYC + 20 && busy; i++) waitq(1);
  endtask

  task automatic testReset();
    checkVal("R1 sdaDriveLow after reset", sdaDriveLow, 1'b0);
    checkVal("R1 busy after reset", busy, 1'b0);
  endtask

  task automatic testMismatch();
    logic ack;
    startCond();
    sendByte(8'hA0, ack);
    checkVal("R2 wrong strap nack", ack, 1'b0);
    sendByte(8'h03, ack);
    checkVal("R2 ignored after mismatch", ack, 1'b0);
    stopCond();
    startCond();
    sendByte(8'h2A, ack);
    checkVal("R2 wrong type nack", ack, 1'b0);
    stopCond();
    checkVal("R6 no busy without data", busy, 1'b0);
  endtask

  task automatic testByteWrite();
    logic ack;
    int len;
    setAddr(12'h345, "bw");
    sendByte(8'h5C, ack);
    checkVal("R4 data ack", ack, 1'b1);
    sdaDrv = 1'b0; waitq(Q);
    sclDrv = 1'b1; waitq(Q);
    sdaDrv = 1'b1;
    waitq(2); checkVal("R6 busy not yet", busy, 1'b0);
    waitq(1); checkVal("R6 busy rises", busy, 1'b1);
    len = 1;
    while (busy && len < WCYC + 50) begin
      waitq(1);
      if (busy) len++;
    end
    checkVal("R6 busy length", len, WCYC);
  endtask

  task automatic testBusyIgnore();
    logic ack;
    setAddr(12'h100, "bi");
    sendByte(8'h77, ack);
    stopCond();
    checkVal("R6 busy after write", busy, 1'b1);
    startCond();
    sendByte(DEV_WR, ack);
    checkVal("R7 nack while busy", ack, 1'b0);
    sendByte(8'h01, ack);
    checkVal("R7 still ignored", ack, 1'b0);
    stopCond();
    waitIdle();
    waitq(5);
    checkVal("R7 no extra write cycle", busy, 1'b0);
  endtask

  task automatic readSeq(input logic [11:0] a, input int n, input logic [7:0] first, input string tag);
    logic ack;
    logic [7:0] b;
    setAddr(a, tag);
    startCond();
    sendByte(DEV_RD, ack);
    checkVal({tag, " R9 read dev ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      checkVal({tag, " R9 read byte"}, b, first + 8'(i));
    end
    stopCond();
    checkVal({tag, " R9 read no busy"}, busy, 1'b0);
  endtask

  task automatic testRandomRead();
    logic ack;
    logic [7:0] b;
    setAddr(12'h345, "rr");
    startCond();
    sendByte(DEV_RD, ack);
    checkVal("R9 dev read ack", ack, 1'b1);
    recvByte(1'b0, b);
    checkVal("R4 readback", b, 8'h5C);
    stopCond();
    checkVal("R4 read leaves busy low", busy, 1'b0);
    // nack ended the read: a fresh read returns the same byte
    startCond();
    sendByte(DEV_RD, ack);
    recvByte(1'b0, b);
    checkVal("R9 counter held after nack", b, 8'h5C);
    stopCond();
  endtask

  task automatic testPageWrap();
    logic ack;
    setAddr(12'h7FC, "pw");
    for (int i = 0; i < 6; i++) begin
      sendByte(8'h10 + 8'(i), ack);
      checkVal("R5 page data ack", ack, 1'b1);
    end
    stopCond();
    waitIdle();
    readSeq(12'h7FC, 4, 8'h10, "R5 page tail");
    readSeq(12'h7E0, 2, 8'h14, "R5 page wrap");
  endtask

  task automatic testProtect();
    logic ack;
    logic [7:0] b;
    wrProtect = 1'b1;
    setAddr(12'h345, "wp");
    sendByte(8'hEE, ack);
    checkVal("R8 protected nack", ack, 1'b0);
    stopCond();
    waitq(5);
    checkVal("R8 no write cycle", busy, 1'b0);
    wrProtect = 1'b0;
    setAddr(12'h345, "wp2");
    startCond();
    sendByte(DEV_RD, ack);
    recvByte(1'b0, b);
    checkVal("R8 array unchanged", b, 8'h5C);
    stopCond();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    waitq(5);
    testReset();
    rstN = 1'b1;
    waitq(5);
    testReset();
    testMismatch();
    testByteWrite();
    testBusyIgnore();
    testRandomRead();
    testPageWrap();
    testProtect();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule